// File: doc/BRIEF.md
# Bit-Serial CRC-16 Peripheral

This block is a CRC-16 accelerator that a processor reaches through two byte-wide registers: control/status at address 0 and data at address 1. Software writes a message one byte at a time to the data register. The block folds each accepted byte into a 16-bit CRC one bit per clock, least significant bit first, using the reflected CCITT polynomial 0x8408. A busy flag in the control register stays set while the fold runs. Reading the data register returns the complemented CRC, first the low byte and then the high byte.

The engine is a three-state machine. `ST_IDLE` accepts a byte. `ST_SHIFT` absorbs bits and reports busy. `ST_LOCK` is a one-cycle guard after busy drops, during which data writes are still refused. The transitions are: IDLE→SHIFT on an accepted write, SHIFT→SHIFT for each of the first seven bits, SHIFT→LOCK after the eighth bit, and LOCK→IDLE on the next cycle. SHIFT and LOCK hold their state while the unit is disabled.

The register side keeps the enable mode as a two-state machine. `MODE_OFF` moves to `MODE_ON` when a control write clears the disable bit. `MODE_ON` moves to `MODE_OFF` when a control write sets it. The OFF→ON transition reloads the CRC to 0xFFFF and points the byte readout at the low byte. Reads are combinational from the current state.

Top module: `crc16_serial_periph`

## Requirements
- R1: After reset the unit is disabled and idle. A control read returns 0x82, and both data bytes read as 0x00 because the CRC holds 0xFFFF. The byte pointer selects the low byte.
- R2: A control read returns bit 7 = 1, bit 1 = disable, bit 0 = busy, and 0 in all other bits. A control write keeps only bit 1. Address 0 selects control and address 1 selects data.
- R3: An accepted byte is folded LSB first, one bit per clock, with crc = (crc >> 1) ^ ((crc[0] ^ bit) ? 0x8408 : 0). Folding the ASCII bytes "123456789" from 0xFFFF gives a readout of 0x906E.
- R4: Busy reads 1 for exactly 8 cycles, starting in the cycle after the byte is accepted.
- R5: A data write is refused while busy is set, and also in the single cycle right after busy clears. The next write after that is accepted.
- R6: While the unit is disabled, data writes are ignored: busy stays 0 and the CRC does not change.
- R7: Setting disable during a fold freezes the CRC and the bit count, with busy still 1. The remaining bits are folded after the unit is re-enabled.
- R8: Clearing disable while the unit is disabled reloads the CRC to 0xFFFF and resets the byte pointer to the low byte.
- R9: The data read value is the complement of the CRC byte that the pointer selects (0 = low, 1 = high). Each read strobe toggles the pointer. Looking at the read data without a strobe leaves the pointer unchanged.
- R10: A data read during a fold shows the partially updated CRC after however many bits have been absorbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 1 | Register select: 0 control, 1 data |
| wen_i | input | 1 | Write strobe |
| ren_i | input | 1 | Read strobe; advances the byte pointer on data reads |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data of the selected register |

## Verification
The assertions assume that the write and read strobes are sampled only on rising edges, and that a control write and a data write never occur in the same cycle. With a single address line, the bench cannot issue both at once. The bench changes inputs only on falling edges and issues one bus operation per cycle. It counts edges from each accepted write, so it knows which state it is probing: data writes are placed inside the busy window and exactly in the guard cycle. It looks at the CRC without read strobes so that the pointer is not disturbed.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned CRC_W    = 16;
    localparam logic [15:0] CRC_POLY = 16'h8408;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    localparam int unsigned CTRL_BUSY_BIT = 0;
    localparam int unsigned CTRL_DIS_BIT  = 1;
    localparam int unsigned CTRL_ONE_BIT  = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOCK  = 2'd2
    } eng_state_t;

    typedef enum logic {
        MODE_OFF = 1'b0,
        MODE_ON  = 1'b1
    } mode_t;
endpackage

// File: rtl/crc16_engine.sv
module crc16_engine
    import crc16_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W,
    parameter int unsigned SUM_W  = CRC_W,
    parameter logic [SUM_W-1:0] POLY = CRC_POLY,
    parameter logic [SUM_W-1:0] SEED = CRC_SEED
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              freeze_i,
    input  logic              seed_i,
    output logic [SUM_W-1:0]  crc_o,
    output logic              busy_o,
    output logic              ready_o
);
    localparam int unsigned CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    eng_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [SUM_W-1:0]  crc_q, crc_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic              fb;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            crc_q   <= SEED;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            crc_q   <= crc_d;
            sh_q    <= sh_d;
        end
    end

    assign fb = crc_q[0] ^ sh_q[0];

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        crc_d   = crc_q;
        sh_d    = sh_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    sh_d    = byte_i;
                    cnt_d   = '0;
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (!freeze_i) begin
                    crc_d = (crc_q >> 1) ^ (fb ? POLY : '0);
                    sh_d  = sh_q >> 1;
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_BIT) state_d = ST_LOCK;
                end
            end
            ST_LOCK: begin
                if (!freeze_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (seed_i) crc_d = SEED;
    end

    always_comb begin
        crc_o   = crc_q;
        busy_o  = (state_q == ST_SHIFT);
        ready_o = (state_q == ST_IDLE);
    end

    // R8
    seed_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seed_i |=> (crc_q == SEED))
        else $error("CRC not reloaded after enable");

    // R7
    freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (freeze_i && !seed_i && state_q != ST_IDLE) |=> ($stable(crc_q) && $stable(cnt_q)))
        else $error("fold advanced while disabled");

    // R4
    shift_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SHIFT && !freeze_i && cnt_q == LAST_BIT) |=> (state_q == ST_LOCK))
        else $error("fold did not end after last bit");
endmodule

// File: rtl/crc16_regif.sv
module crc16_regif
    import crc16_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W,
    parameter int unsigned SUM_W  = CRC_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              addr_i,
    input  logic              wen_i,
    input  logic              ren_i,
    input  logic              dis_bit_i,
    input  logic [SUM_W-1:0]  crc_i,
    input  logic              busy_i,
    input  logic              ready_i,
    output logic              start_o,
    output logic              seed_o,
    output logic              freeze_o,
    output logic [DATA_W-1:0] rdata_o
);
    mode_t mode_q, mode_d;
    logic  ptr_q, ptr_d;
    logic  ctrl_wr, data_wr, data_rd;
    logic [SUM_W-1:0]  crc_n;
    logic [DATA_W-1:0] ctrl_rd;

    assign ctrl_wr = wen_i && !addr_i;
    assign data_wr = wen_i &&  addr_i;
    assign data_rd = ren_i &&  addr_i;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q <= MODE_OFF;
            ptr_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            ptr_q  <= ptr_d;
        end
    end

    always_comb begin
        mode_d = mode_q;
        seed_o = 1'b0;
        unique case (mode_q)
            MODE_OFF: if (ctrl_wr && !dis_bit_i) begin
                mode_d = MODE_ON;
                seed_o = 1'b1;
            end
            MODE_ON: if (ctrl_wr && dis_bit_i) mode_d = MODE_OFF;
            default: mode_d = MODE_OFF;
        endcase
        ptr_d = ptr_q;
        if (seed_o)       ptr_d = 1'b0;
        else if (data_rd) ptr_d = ~ptr_q;
    end

    always_comb begin
        freeze_o = (mode_q == MODE_OFF);
        start_o  = data_wr && (mode_q == MODE_ON) && ready_i;
        crc_n    = ~crc_i;
        ctrl_rd  = '0;
        ctrl_rd[CTRL_ONE_BIT]  = 1'b1;
        ctrl_rd[CTRL_DIS_BIT]  = (mode_q == MODE_OFF);
        ctrl_rd[CTRL_BUSY_BIT] = busy_i;
        if (!addr_i)    rdata_o = ctrl_rd;
        else if (ptr_q) rdata_o = crc_n[SUM_W-1 -: DATA_W];
        else            rdata_o = crc_n[DATA_W-1:0];
    end

    // R9
    ptr_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_rd && !seed_o) |=> (ptr_q != $past(ptr_q)))
        else $error("pointer did not advance");

    // R4
    start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> busy_i)
        else $error("no busy after accept");

    // R5
    lock_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |-> !start_o)
        else $error("write accepted while busy");

    // R6
    off_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == MODE_OFF) |-> !start_o)
        else $error("write accepted while disabled");
endmodule

// File: rtl/crc16_serial_periph.sv
module crc16_serial_periph
    import crc16_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              addr_i,
    input  logic              wen_i,
    input  logic              ren_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o
);
    logic [CRC_W-1:0] crc;
    logic busy, ready, start, seed, freeze;

    crc16_engine #(
        .DATA_W (BYTE_W),
        .SUM_W  (CRC_W),
        .POLY   (CRC_POLY),
        .SEED   (CRC_SEED)
    ) engine_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start),
        .byte_i   (wdata_i),
        .freeze_i (freeze),
        .seed_i   (seed),
        .crc_o    (crc),
        .busy_o   (busy),
        .ready_o  (ready)
    );

    crc16_regif #(
        .DATA_W (BYTE_W),
        .SUM_W  (CRC_W)
    ) regif_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .addr_i    (addr_i),
        .wen_i     (wen_i),
        .ren_i     (ren_i),
        .dis_bit_i (wdata_i[CTRL_DIS_BIT]),
        .crc_i     (crc),
        .busy_i    (busy),
        .ready_i   (ready),
        .start_o   (start),
        .seed_o    (seed),
        .freeze_o  (freeze),
        .rdata_o   (rdata_o)
    );
endmodule

// File: tb/crc16_serial_periph_tb.sv
module crc16_serial_periph_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr = 1'b0, wen = 1'b0, ren = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [15:0] model;

    always #5 clk = ~clk;

    crc16_serial_periph dut_i (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wen_i(wen),
        .ren_i(ren), .wdata_i(wdata), .rdata_o(rdata)
    );

    function automatic logic [15:0] fold(logic [15:0] c, logic [7:0] b, int lo, int hi);
        for (int i = lo; i < hi; i++)
            c = (c >> 1) ^ ((c[0] ^ b[i]) ? 16'h8408 : 16'h0000);
        return c;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_cycle();
        addr = 1'b0; wen = 1'b0; ren = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_write(logic a, logic [7:0] d);
        addr = a; wen = 1'b1; ren = 1'b0; wdata = d;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic bus_read(logic a, output logic [7:0] d);
        addr = a; wen = 1'b0; ren = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        ren = 1'b0;
    endtask

    task automatic peek(logic a, output logic [7:0] d);
        addr = a; wen = 1'b0; ren = 1'b0;
        #1 d = rdata;
    endtask

    task automatic read_sum(output logic [15:0] s);
        logic [7:0] lo, hi;
        bus_read(1'b1, lo);
        bus_read(1'b1, hi);
        s = {hi, lo};
    endtask

    task automatic enable_fresh();
        bus_write(1'b0, 8'h02);
        bus_write(1'b0, 8'h00);
        model = 16'hFFFF;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(1'b0, v); check("R1 ctrl after reset", v, 8'h82);
        peek(1'b1, v); check("R1 low byte after reset", v, 8'h00);
        bus_read(1'b1, v);
        bus_read(1'b1, v); check("R1 high byte after reset", v, 8'h00);
        bus_read(1'b1, v);
    endtask

    task automatic t_ctrl_format();
        logic [7:0] v;
        bus_write(1'b0, 8'h7D);
        model = 16'hFFFF;
        peek(1'b0, v); check("R2 ctrl keeps only disable bit", v, 8'h80);
        bus_write(1'b0, 8'hFF);
        peek(1'b0, v); check("R2 ctrl disabled readback", v, 8'h82);
        bus_write(1'b0, 8'h00);
    endtask

    task automatic t_single_byte(logic [7:0] b);
        logic [7:0] v;
        logic [15:0] s;
        enable_fresh();
        bus_write(1'b1, b);
        for (int k = 0; k < 8; k++) begin
            peek(1'b0, v); check("R4 busy during fold", v, 8'h81);
            peek(1'b1, v);
            check("R10 partial CRC low byte", v, ~fold(model, b, 0, k) & 16'h00FF);
            @(negedge clk);
        end
        peek(1'b0, v); check("R4 busy clear after 8 cycles", v, 8'h80);
        idle_cycle();
        model = fold(model, b, 0, 8);
        read_sum(s); check("R3 R9 full fold readout", s, ~model);
    endtask

    task automatic t_lockout();
        logic [7:0] v;
        logic [15:0] s;
        enable_fresh();
        bus_write(1'b1, 8'h3C);
        for (int k = 0; k < 9; k++) begin
            if (k == 3 || k == 8) begin
                bus_write(1'b1, 8'hE7);
            end else begin
                idle_cycle();
            end
        end
        model = fold(model, 8'h3C, 0, 8);
        peek(1'b0, v); check("R5 not busy after refused writes", v, 8'h80);
        read_sum(s); check("R5 refused bytes left CRC alone", s, ~model);
        bus_write(1'b1, 8'h11);
        peek(1'b0, v); check("R5 write after guard accepted", v, 8'h81);
        repeat (9) idle_cycle();
        model = fold(model, 8'h11, 0, 8);
        read_sum(s); check("R5 CRC after accepted byte", s, ~model);
    endtask

    task automatic t_vector();
        logic [15:0] s;
        string msg = "123456789";
        enable_fresh();
        for (int i = 0; i < 9; i++) begin
            bus_write(1'b1, msg[i]);
            repeat (9) idle_cycle();
            model = fold(model, msg[i], 0, 8);
        end
        read_sum(s);
        check("R3 check vector", s, 16'h906E);
        check("R3 model agrees", ~model, 16'h906E);
    endtask

    task automatic t_disabled_write();
        logic [7:0] v;
        logic [15:0] s;
        enable_fresh();
        bus_write(1'b1, 8'h5A);
        repeat (9) idle_cycle();
        model = fold(model, 8'h5A, 0, 8);
        bus_write(1'b0, 8'h02);
        bus_write(1'b1, 8'h99);
        peek(1'b0, v); check("R6 no busy when disabled", v, 8'h82);
        repeat (9) idle_cycle();
        read_sum(s); check("R6 CRC unchanged while disabled", s, ~model);
    endtask

    task automatic t_freeze();
        logic [7:0] v, a, b;
        logic [15:0] s;
        enable_fresh();
        bus_write(1'b1, 8'hC3);
        repeat (2) idle_cycle();
        bus_write(1'b0, 8'h02);
        peek(1'b1, a);
        check("R7 frozen after 3 bits", a, ~fold(model, 8'hC3, 0, 3) & 16'h00FF);
        repeat (5) idle_cycle();
        peek(1'b1, b); check("R7 CRC stays frozen", b, a);
        peek(1'b0, v); check("R7 busy held while frozen", v, 8'h83);
        bus_write(1'b0, 8'h00);
        model = 16'hFFFF;
        peek(1'b1, v); check("R8 reload on enable", v, 8'h00);
        repeat (5) idle_cycle();
        peek(1'b0, v); check("R7 fold finished after resume", v, 8'h80);
        idle_cycle();
        model = fold(model, 8'hC3, 3, 8);
        read_sum(s); check("R7 remaining bits folded", s, ~model);
    endtask

    task automatic t_pointer();
        logic [7:0] v, w;
        logic [15:0] s;
        enable_fresh();
        bus_write(1'b1, 8'h81);
        repeat (9) idle_cycle();
        model = fold(model, 8'h81, 0, 8);
        s = ~model;
        peek(1'b1, v); idle_cycle(); peek(1'b1, w);
        check("R9 peek does not advance", w, v);
        bus_read(1'b1, v); check("R9 first read low", v, s[7:0]);
        bus_read(1'b1, v); check("R9 second read high", v, s[15:8]);
        bus_read(1'b1, v); check("R9 third read low again", v, s[7:0]);
        bus_write(1'b0, 8'h02);
        bus_write(1'b0, 8'h00);
        bus_read(1'b1, v); check("R8 pointer back to low", v, 8'h00);
        bus_read(1'b1, v); check("R8 high after reload", v, 8'h00);
    endtask

    initial begin
        model = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_format();
        t_single_byte(8'hA5);
        t_single_byte(8'h00);
        t_lockout();
        t_vector();
        t_disabled_write();
        t_freeze();
        t_pointer();
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule